// File: doc/BRIEF.md
# Interrupt Target Routing Register Bank

This block keeps, for every interrupt line of a distributed interrupt controller, an eight-bit mask naming the cores the interrupt may be sent to. Software reaches the masks through a byte-addressed register window in which the interrupt number equals the byte offset. An access is either a full word, covering four neighbouring interrupts at once, or a single byte, covering one.

The first 32 interrupts are private to each core. Their entries cannot be changed, and a read of one of them returns a mask holding only the requesting core's bit. For every shared interrupt the bank also keeps a single chosen destination core. That core is the lowest-numbered core in the mask, or core 0 when the mask is empty. A delivery stage looks it up through a separate combinational lookup port.

Top module: `irq_target_bank`

## Requirements
- R1: After reset every shared mask reads as zero and the chosen core of every interrupt is 0.
- R2: A word write to a shared entry stores byte lane k of the write data (bits 8k+7..8k) as the mask of interrupt base+k, where base is the address with its two low bits cleared. A word read returns the mask of interrupt base+k in byte lane k.
- R3: A byte write stores write-data lane addr[1:0] as the mask of interrupt addr. All other entries keep their values.
- R4: A byte read returns the mask of interrupt addr in byte lane addr[1:0], and the other three lanes read zero.
- R5: Writes to interrupts 0 to 31 are ignored. Reading any of these entries returns, in each covered lane, a mask with only bit req_core set.
- R6: Entries at or beyond NUM_IRQ read as zero, and writes to them are ignored.
- R7: After a write to a shared entry, the chosen core of that interrupt is the index of the lowest set bit of the new mask, or 0 for an all-zero mask. route_core shows it in the cycle after the write.
- R8: rsp_valid is high exactly in the cycle after a read request, and rsp_rdata is valid with it. A write never raises rsp_valid.
- R9: A word access ignores address bits 1..0 and always covers the four interrupts of the aligned group.
- R10: route_core is 0 for a private interrupt and for an index at or beyond NUM_IRQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = word access (four interrupts), 0 = byte access |
| req_addr | input | 10 | Byte offset, equal to the interrupt number |
| req_wdata | input | 32 | Write data, one mask per byte lane |
| req_core | input | 3 | Number of the core making the access |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, one mask per byte lane |
| route_idx | input | 10 | Interrupt number to look up |
| route_core | output | 3 | Chosen destination core of route_idx |

## Verification
The properties assume that at most one access is presented per cycle, that req_core is stable while req_valid is high, and that route_idx changes only between clock edges. The bench holds to these assumptions. It drives every input at the falling edge and keeps each request for exactly one cycle. Between requests it returns req_valid to low, so each read has a response slot to itself. Addresses cover the private range, the shared range up to the last entry, and the range beyond NUM_IRQ, so every lane decode path the properties assume is reached.

// File: rtl/irq_tgt_pkg.sv
package irq_tgt_pkg;
    localparam int MASK_W   = 8;
    localparam int LANES    = 4;
    localparam int PRIV_IRQ = 32;
    localparam int ADDR_W   = 10;
    localparam int CORE_W   = $clog2(MASK_W);
    localparam int DATA_W   = MASK_W * LANES;

    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [CORE_W-1:0] core_t;

    typedef struct packed {
        logic              active;
        logic              priv;
        logic              shared;
        logic [ADDR_W-1:0] irq;
    } lane_sel_t;
endpackage

// File: rtl/irq_tgt_lane_dec.sv
module irq_tgt_lane_dec
    import irq_tgt_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int LANE    = 0
) (
    input  logic              req_valid,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    output lane_sel_t         sel
);
    logic [ADDR_W-1:0] irq;

    always_comb begin
        irq        = req_wide ? {req_addr[ADDR_W-1:2], 2'(LANE)} : req_addr;
        sel.active = req_valid && (req_wide || (req_addr[1:0] == 2'(LANE)));
        sel.priv   = irq < ADDR_W'(PRIV_IRQ);
        sel.shared = !sel.priv && (irq < ADDR_W'(NUM_IRQ));
        sel.irq    = irq;
    end
endmodule

// File: rtl/irq_tgt_lowbit.sv
module irq_tgt_lowbit
    import irq_tgt_pkg::*;
(
    input  mask_t mask,
    output core_t core
);
    always_comb begin
        core = '0;
        for (int b = MASK_W - 1; b >= 0; b--) begin
            if (mask[b]) core = CORE_W'(b);
        end
    end
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank
    import irq_tgt_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CORE_W-1:0] req_core,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [ADDR_W-1:0] route_idx,
    output logic [CORE_W-1:0] route_core
);
    localparam int SHARED = NUM_IRQ - PRIV_IRQ;

    typedef struct packed {
        mask_t [SHARED-1:0] mask;
        core_t [SHARED-1:0] pick;
        logic               rvalid;
        logic [DATA_W-1:0]  rdata;
    } state_t;

    state_t    state_d, state_q;
    lane_sel_t lane_sel  [LANES];
    core_t     lane_pick [LANES];
    mask_t     own_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        irq_tgt_lane_dec #(
            .NUM_IRQ (NUM_IRQ),
            .LANE    (l)
        ) u_dec (
            .req_valid (req_valid),
            .req_wide  (req_wide),
            .req_addr  (req_addr),
            .sel       (lane_sel[l])
        );

        irq_tgt_lowbit u_pick (
            .mask (req_wdata[MASK_W*l +: MASK_W]),
            .core (lane_pick[l])
        );
    end

    assign own_mask = mask_t'(1) << req_core;

    always_comb begin
        state_d        = state_q;
        state_d.rvalid = req_valid && !req_write;
        state_d.rdata  = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_sel[l].active) begin
                if (req_write) begin
                    if (lane_sel[l].shared) begin
                        for (int e = 0; e < SHARED; e++) begin
                            if (lane_sel[l].irq == ADDR_W'(e + PRIV_IRQ)) begin
                                state_d.mask[e] = req_wdata[MASK_W*l +: MASK_W];
                                state_d.pick[e] = lane_pick[l];
                            end
                        end
                    end
                end else if (lane_sel[l].priv) begin
                    state_d.rdata[MASK_W*l +: MASK_W] = own_mask;
                end else if (lane_sel[l].shared) begin
                    for (int e = 0; e < SHARED; e++) begin
                        if (lane_sel[l].irq == ADDR_W'(e + PRIV_IRQ)) begin
                            state_d.rdata[MASK_W*l +: MASK_W] = state_q.mask[e];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        route_core = '0;
        for (int e = 0; e < SHARED; e++) begin
            if (route_idx == ADDR_W'(e + PRIV_IRQ)) route_core = state_q.pick[e];
        end
    end

    assign rsp_valid = state_q.rvalid;
    assign rsp_rdata = state_q.rdata;
endmodule

// File: rtl/irq_target_bank_chk.sv
module irq_target_bank_chk
    import irq_tgt_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_wide,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CORE_W-1:0] req_core,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [ADDR_W-1:0] route_idx,
    input logic [CORE_W-1:0] route_core
);
    logic rd_req;
    assign rd_req = req_valid && !req_write;

    assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

    assert_no_rsp_otherwise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

    assert_private_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_wide && req_addr < ADDR_W'(PRIV_IRQ))
        |=> rsp_rdata == {LANES{mask_t'(mask_t'(1) << $past(req_core))}});

    assert_beyond_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !req_wide && req_addr >= ADDR_W'(NUM_IRQ)) |=> rsp_rdata == '0);

    assert_byte_read_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !req_wide)
        |=> (rsp_rdata & ~(DATA_W'(8'hFF) << (MASK_W * $past(req_addr[1:0])))) == '0);

    assert_route_private_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (route_idx < ADDR_W'(PRIV_IRQ)) |-> route_core == '0);
endmodule

bind irq_target_bank irq_target_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_wide   (req_wide),
    .req_addr   (req_addr),
    .req_core   (req_core),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .route_idx  (route_idx),
    .route_core (route_core)
);

// File: tb/irq_target_bank_bench.sv
module irq_target_bank_bench;
    localparam int NUM_IRQ = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  req_core = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [9:0]  route_idx = '0;
    logic [2:0]  route_core;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0]  model [NUM_IRQ];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    irq_target_bank #(.NUM_IRQ(NUM_IRQ)) u_irq_target_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wide   (req_wide),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_core   (req_core),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .route_idx  (route_idx),
        .route_core (route_core)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] low_core(input logic [7:0] m);
        for (int b = 0; b < 8; b++) if (m[b]) return 3'(b);
        return 3'd0;
    endfunction

    function automatic logic [31:0] exp_read(input bit wide, input int addr, input int core);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            int irq;
            logic [7:0] b;
            if (!wide && k != (addr & 3)) continue;
            irq = wide ? (addr & ~3) + k : addr;
            if (irq < 32)           b = 8'(1 << core);
            else if (irq < NUM_IRQ) b = model[irq];
            else                    b = 8'h00;
            r[8*k +: 8] = b;
        end
        return r;
    endfunction

    task automatic wr(input bit wide, input int addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = wide;
        req_addr = 10'(addr); req_wdata = data;
        for (int k = 0; k < 4; k++) begin
            int irq;
            int lane;
            if (!wide && k > 0) break;
            irq  = wide ? (addr & ~3) + k : addr;
            lane = wide ? k : (addr & 3);
            if (irq >= 32 && irq < NUM_IRQ) model[irq] = data[8*lane +: 8];
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input bit wide, input int addr, input int core, input string tag);
        @(negedge clk);
        exp_q.push_back(exp_read(wide, addr, core));
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_wide = wide;
        req_addr = 10'(addr); req_core = 3'(core);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic route(input int idx, input string tag);
        logic [2:0] e;
        @(negedge clk);
        route_idx = 10'(idx);
        #1;
        e = (idx >= 32 && idx < NUM_IRQ) ? low_core(model[idx]) : 3'd0;
        check(tag, 32'(route_core), 32'(e));
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R8: actual rsp_valid 1 expected 0 (no read pending)");
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NUM_IRQ; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(1, 32, 0, "R1 reset shared word");
        rd(1, 60, 0, "R1 reset last word");
        route(33, "R1 reset route");

        wr(1, 32, 32'h8004_0006);
        check("R8 write gives no response", 32'(rsp_valid), 32'd0);
        rd(1, 32, 0, "R2 word readback");
        route(32, "R7 route lowest bit 1");
        route(33, "R7 route empty mask");
        route(34, "R7 route lowest bit 2");
        route(35, "R7 route bit 7");

        wr(0, 37, 32'hAAAA_30AA);
        rd(1, 36, 0, "R3 byte write neighbours");
        rd(0, 37, 0, "R4 byte read lane 1");
        rd(0, 34, 0, "R4 byte read lane 2");
        route(37, "R7 route after byte write");

        wr(1, 0, 32'hFFFF_FFFF);
        wr(0, 7, 32'hFFFF_FFFF);
        rd(1, 0, 5, "R5 private word read core 5");
        rd(0, 7, 2, "R5 private byte read core 2");
        route(5, "R10 private route");

        wr(1, 64, 32'h1234_5678);
        rd(1, 64, 0, "R6 beyond range word");
        rd(0, 66, 0, "R6 beyond range byte");
        route(64, "R10 beyond range route");

        wr(1, 41, 32'h0102_0408);
        rd(1, 43, 0, "R9 unaligned word read");
        route(40, "R9 unaligned write lane 0");
        route(43, "R9 unaligned write lane 3");

        wr(0, 63, 32'hC000_0000);
        rd(0, 63, 0, "R4 last entry byte read");
        route(63, "R7 last entry route");

        wr(0, 32, 32'h0000_0000);
        route(32, "R7 cleared mask to core 0");
        rd(1, 32, 0, "R3 clear one byte only");

        repeat (3) @(negedge clk);
        check("R8 all responses seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule